// File: doc/BRIEF.md
# Dual-Mode UART Baud Tick Generator

This block turns the system clock into a 16x oversampling tick for UART transmit and receive bit timing. Software writes two values over a small write-only register port: a 16-bit rate value and a control word. The block makes no attempt to compute either value. The control word holds a run bit, which gates the whole generator, and a mode bit, which picks how the rate value is used.

In divider mode the rate value is an integer divisor: the clock frequency divided by sixteen times the bit rate. A down-counter issues one tick each time it expires. In accumulator mode the rate value is a phase increment, equal to sixteen times the bit rate times 2^16, divided by the clock frequency. It is added to a 16-bit phase every clock, and each carry out of the phase becomes a tick. This gives fine rate resolution at high bit rates, typically above 19200 baud. Below that rate the divider is the usual choice unless the accumulator is forced.

The tick is a single-cycle pulse synchronous to the clock. Writing a new rate value restarts whichever engine is active, so a new rate takes effect from a clean phase.

Top module: `baudgen_top`

## Requirements
- R1: After reset, `tick_16x` is 0, the run bit is clear, divider mode is selected and the rate value is 0. No tick appears until the run bit is set.
- R2: A write with `reg_sel`=1 loads the control word. Bit 7 is run and bit 12 selects accumulator mode (1) or divider mode (0). All other bits of the control word have no effect.
- R3: In divider mode with rate value D>=2 and run set, ticks come every D cycles. The first tick is seen one clock after the first enabled cycle that follows a restart.
- R4: In divider mode, a rate value of 0 or 1 gives a tick on every clock cycle while running.
- R5: In accumulator mode with increment I, the n-th enabled cycle after a restart gives a tick exactly when floor(n*I/65536) exceeds floor((n-1)*I/65536), which is the carry out of a 17-bit sum. The lower 16 bits of that sum are kept as the phase.
- R6: In accumulator mode, an increment of 0 never produces a tick.
- R7: While run is clear, `tick_16x` is 0 from the edge that clears run onward. Both engines are held at their cleared state, so setting run again starts from a fresh phase.
- R8: A write with `reg_sel`=0 loads the rate value and restarts the active engine in that same edge: the divider count is cleared, or the accumulator phase is cleared.
- R9: Changing the mode bit starts the newly selected engine from its cleared state. From the edge that changes the mode onward, the output follows the newly selected engine.
- R10: `tick_16x` is a one-cycle pulse. In divider mode with D>=2 it is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | 0 selects the rate value, 1 selects the control word |
| reg_wdata | input | 16 | Write data |
| tick_16x | output | 1 | Oversampling tick, one clock wide |

## Verification
A write presented before an edge is captured at that edge. The captured rate value and control bits steer the engines from the following cycle, so a divider tick first shows one edge after the first enabled cycle, and an accumulator carry shows at the edge that completes the sum that produced it. The output gating by run and mode acts at the same edge that updates the registers. The bench advances a behavioural model at each rising edge from the inputs that were present before it. It compares `tick_16x` on every falling edge, which lands each check exactly on the cycle in which the result is due.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  localparam int unsigned RATE_W_DEF   = 16;
  localparam int unsigned RUN_POS_DEF  = 7;
  localparam int unsigned MODE_POS_DEF = 12;

  typedef enum logic {
    SEL_RATE = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  typedef enum logic {
    MODE_DIV = 1'b0,
    MODE_ACC = 1'b1
  } gen_mode_e;
endpackage

// File: rtl/baudgen_regs.sv
module baudgen_regs
  import baudgen_pkg::*;
#(
  parameter int unsigned RATE_W   = RATE_W_DEF,
  parameter int unsigned RUN_POS  = RUN_POS_DEF,
  parameter int unsigned MODE_POS = MODE_POS_DEF
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [RATE_W-1:0] wdata_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              run_o,
  output gen_mode_e         mode_o,
  output logic              restart_o
);
  logic              rate_we, ctrl_we;
  logic [RATE_W-1:0] rate_q;
  logic              run_q;
  gen_mode_e         mode_q;

  always_comb begin
    rate_we = wr_i && (reg_sel_e'(sel_i) == SEL_RATE);
    ctrl_we = wr_i && (reg_sel_e'(sel_i) == SEL_CTRL);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
    end else if (rate_we) begin
      rate_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= MODE_DIV;
    end else if (ctrl_we) begin
      run_q  <= wdata_i[RUN_POS];
      mode_q <= gen_mode_e'(wdata_i[MODE_POS]);
    end
  end

  assign rate_o    = rate_q;
  assign run_o     = run_q;
  assign mode_o    = mode_q;
  assign restart_o = rate_we;
endmodule

// File: rtl/baudgen_div.sv
module baudgen_div #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [RATE_W-1:0] divisor_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q, cnt_d, reload;
  logic              tick_q, tick_d, expired;

  always_comb begin
    reload  = (divisor_i <= RATE_W'(1)) ? '0 : divisor_i - RATE_W'(1);
    expired = (cnt_q == '0);
    tick_d  = en_i && !restart_i && expired;
    if (restart_i || !en_i) begin
      cnt_d = '0;
    end else if (expired) begin
      cnt_d = reload;
    end else begin
      cnt_d = cnt_q - RATE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R7: an idle divider issues nothing in the next cycle
  a_r7_div_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |=> !tick_q);
  // R10: with a divisor of two or more a tick is never followed by another
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && tick_q && divisor_i > RATE_W'(1)) |=> !tick_q);
  // R4: divisor 0 or 1 ticks every enabled cycle
  a_r4_every_cycle: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && !restart_i && divisor_i <= RATE_W'(1)) |=> tick_q);
endmodule

// File: rtl/baudgen_acc.sv
module baudgen_acc #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [RATE_W-1:0] inc_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] phase_q, phase_d;
  logic [RATE_W:0]   sum;
  logic              tick_q, tick_d;

  always_comb begin
    sum = {1'b0, phase_q} + {1'b0, inc_i};
    if (restart_i || !en_i) begin
      phase_d = '0;
      tick_d  = 1'b0;
    end else begin
      phase_d = sum[RATE_W-1:0];
      tick_d  = sum[RATE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tick_q  <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R7: a disabled accumulator is cleared and silent
  a_r7_acc_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |=> (!tick_q && phase_q == '0));
  // R6: a zero increment never carries
  a_r6_zero_inc: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && inc_i == '0) |=> !tick_q);
  // R8: a restart clears the phase
  a_r8_acc_restart: assert property (@(posedge clk) disable iff (!rst_ni)
    restart_i |=> (phase_q == '0 && !tick_q));
endmodule

// File: rtl/baudgen_top.sv
module baudgen_top
  import baudgen_pkg::*;
#(
  parameter int unsigned RATE_W   = RATE_W_DEF,
  parameter int unsigned RUN_POS  = RUN_POS_DEF,
  parameter int unsigned MODE_POS = MODE_POS_DEF,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [RATE_W-1:0] reg_wdata,
  output logic              tick_16x
);
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_ni;
  logic [RATE_W-1:0] rate;
  logic              run, restart, en_div, en_acc, tick_div, tick_acc;
  gen_mode_e         mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[SYNC_N-1];

  baudgen_regs #(.RATE_W(RATE_W), .RUN_POS(RUN_POS), .MODE_POS(MODE_POS)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_i(reg_wr), .sel_i(reg_sel),
    .wdata_i(reg_wdata), .rate_o(rate), .run_o(run), .mode_o(mode),
    .restart_o(restart)
  );

  always_comb begin
    en_div = run && (mode == MODE_DIV);
    en_acc = run && (mode == MODE_ACC);
  end

  baudgen_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_ni(rst_ni), .en_i(en_div), .restart_i(restart),
    .divisor_i(rate), .tick_o(tick_div)
  );

  baudgen_acc #(.RATE_W(RATE_W)) u_acc (
    .clk(clk), .rst_ni(rst_ni), .en_i(en_acc), .restart_i(restart),
    .inc_i(rate), .tick_o(tick_acc)
  );

  assign tick_16x = run && ((mode == MODE_ACC) ? tick_acc : tick_div);

  // R9: a mode change never lets the new engine tick in its first cycle
  a_r9_mode_switch: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode != $past(mode)) |-> !tick_16x);
  // R1: nothing ticks while run is clear
  a_r1_stopped: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(!run) && !run) |-> (!tick_div && !tick_acc));
endmodule

// File: tb/test_baudgen_top.sv
`timescale 1ns/100ps
module test_baudgen_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_sel;
  logic [15:0] reg_wdata;
  logic        tick_16x;

  int    n_checks = 0, n_fail = 0;
  bit    done = 1'b0, model_live = 1'b0;
  string tag = "R1";

  // model state
  bit      m_run, m_acc;
  int      m_rate;
  longint  n_div, n_acc;
  bit      t_div, t_acc, exp_tick, prev_tick;

  always #2.5 clk = ~clk;

  baudgen_top i_baudgen_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .tick_16x(tick_16x)
  );

  always @(posedge clk) begin
    if (!model_live) begin
      m_run = 0; m_acc = 0; m_rate = 0; n_div = 0; n_acc = 0;
      t_div = 0; t_acc = 0; exp_tick = 0;
    end else begin
      bit rst_eng;
      int dp;
      rst_eng = reg_wr && !reg_sel;
      if (rst_eng || !(m_run && !m_acc)) begin
        n_div = 0; t_div = 0;
      end else begin
        dp = (m_rate <= 1) ? 1 : m_rate;
        n_div++;
        t_div = ((n_div - 1) % dp) == 0;
      end
      if (rst_eng || !(m_run && m_acc)) begin
        n_acc = 0; t_acc = 0;
      end else begin
        n_acc++;
        t_acc = ((n_acc * m_rate) >> 16) != (((n_acc - 1) * m_rate) >> 16);
      end
      if (reg_wr && !reg_sel) m_rate = reg_wdata;
      if (reg_wr && reg_sel) begin
        m_run = reg_wdata[7];
        m_acc = reg_wdata[12];
      end
      exp_tick = m_run && (m_acc ? t_acc : t_div);
    end
  end

  task automatic check(bit act, bit exp, string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s tick_16x actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(tick_16x, exp_tick, tag);
      if (tag == "R10") begin
        n_checks++;
        if (tick_16x && prev_tick) begin
          n_fail++;
          $display("FAIL R10 back-to-back tick actual=1 expected=0 at %0t", $time);
        end
      end
      prev_tick = tick_16x;
    end
  end

  task automatic write(bit sel, logic [15:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    reg_wr = 0; reg_sel = 0; reg_wdata = '0; rst_n = 0; prev_tick = 0;
    idle(3);
    check(tick_16x, 1'b0, "R1");
    rst_n = 1; model_live = 1;
    idle(8);
    tag = "R3";  write(0, 16'd4); write(1, 16'h0080); idle(40);
    tag = "R10"; idle(10);
    tag = "R8";  write(0, 16'd7); idle(50);
    tag = "R4";  write(0, 16'd1); idle(10); write(0, 16'd0); idle(10);
    tag = "R2";  write(1, 16'hEF7F); idle(20);
    tag = "R3";  write(0, 16'd3); write(1, 16'h0080 | 16'h6F00 & ~16'h1000); idle(20);
    tag = "R5";  write(1, 16'h1080); write(0, 16'h4000); idle(40);
    write(0, 16'h2AAB); idle(100); write(0, 16'hFFFF); idle(20);
    tag = "R6";  write(0, 16'h0000); idle(30);
    tag = "R9";  write(0, 16'd5); write(1, 16'h0080); idle(30);
    write(1, 16'h1080); write(0, 16'h5000); idle(30);
    tag = "R7";  write(1, 16'h1000); idle(15); write(1, 16'h1080); idle(30);
    write(1, 16'h0000); idle(10);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule